// File: doc/BRIEF.md
# Flash Write Completion Poller

This host-side controller drives a flash program or erase operation over a simple synchronous memory bus. When `start` is sampled high while the block is idle, it captures the operation code, the detection method, the target address and the program data. It then issues the unlock and command writes, one per cycle. After that it polls the target location until the internal operation of the flash is finished. The flash array is not part of the block.

Two detection methods are available. The first compares bit 7 of each read with bit 7 of the expected word, which is the program data or all ones after an erase. The second waits until bit 6 holds still between two consecutive reads. When the status bit says "finished" but the word read back is not the expected word, the read may have raced the completion. The controller then reads the location twice more before it decides between success and a genuine failure. A cycle limit on the poll phase guards against a flash that never finishes.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `error`, `timeout`, `mem_we` and `mem_re` are all low.
- R2: A program (`op`=0) issues four writes on consecutive cycles: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0), then (target address, program data).
- R3: An erase issues six writes on consecutive cycles: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), then a last write. That last write is (target,0x30) for `op`=1 (sector), (target,0x50) for `op`=2 (block) or (0x5555,0x10) for `op`=3 (chip).
- R4: Polling begins on the cycle right after the last command write. Each read asserts `mem_re` for one cycle at the target address, and the data is taken from `mem_rdata` on the following cycle, so a read is never issued on two cycles in a row.
- R5: With `toggle_mode`=0, a read whose bit 7 equals bit 7 of the expected word, and whose whole word equals the expected word, ends the operation with `done`. The expected word is the program data for a program and all ones for any erase.
- R6: With `toggle_mode`=1, a read whose bit 6 equals bit 6 of the previous read in the same operation, and whose whole word equals the expected word, ends the operation with `done`.
- R7: If the status bit reports completion but the word differs from the expected word, exactly two more reads follow. `done` is raised if both of them return the expected word, and `error` otherwise.
- R8: The poll phase lasts at most `TIMEOUT_CYC` cycles. If no decision has been reached by then, `timeout` is raised and the block returns to idle. A done or error decision taken in the last allowed cycle wins over the timeout.
- R9: `start` has no effect while `busy` is high. It starts no writes and does not change the operation in progress.
- R10: Each operation ends with exactly one single-cycle pulse on one of `done`, `error` or `timeout`. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, accepted only while idle |
| op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| toggle_mode | input | 1 | 0 bit-7 data polling, 1 bit-6 toggle detection |
| target_addr | input | AW | Location programmed, erased and polled |
| prog_data | input | DW | Word to program |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_re | output | 1 | Single-cycle read strobe |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Genuine failure pulse |
| timeout | output | 1 | Poll limit exceeded pulse |

## Verification
Completion detection and timeout expiry can fall in the same cycle. This happens when the first read that shows the finished status is evaluated in the last cycle the poll limit allows. The bench runs the bench-side flash model with a busy time picked so that this read lands exactly on the final allowed cycle. It expects `done` with no `timeout`. One cycle more of busy time must give `timeout` alone. A sweep through the confirm path checks that a read racing the completion leads to two extra reads and not to a false failure.

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TIMEOUT_CYC = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          toggle_mode,
  input  logic [AW-1:0] target_addr,
  input  logic [DW-1:0] prog_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          timeout
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [AW-1:0] ADR_A = AW'(20'h5555);
  localparam logic [AW-1:0] ADR_B = AW'(20'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_PRD, S_PEV, S_CRD, S_CEV} state_t;
  state_t state;

  logic [1:0]    op_q;
  logic          tog_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    step;
  logic [TW-1:0] timer;
  logic          prev6, have_prev;
  logic          conf_n, conf_bad;
  logic [AW-1:0] cmd_a;
  logic [DW-1:0] cmd_d;

  wire [DW-1:0] exp_word  = (op_q == 2'd0) ? data_q : '1;
  wire [2:0]    last_step = (op_q == 2'd0) ? 3'd3 : 3'd5;
  wire          rd_ok     = (mem_rdata == exp_word);
  wire          tlast     = (timer == T_LAST);
  wire          hit       = tog_q ? (have_prev && prev6 == mem_rdata[6])
                                  : (mem_rdata[7] == exp_word[7]);

  always_comb begin
    cmd_a = ADR_A;
    cmd_d = DW'(8'hAA);
    case (step)
      3'd0: ;
      3'd1: begin cmd_a = ADR_B; cmd_d = DW'(8'h55); end
      3'd2: cmd_d = (op_q == 2'd0) ? DW'(8'hA0) : DW'(8'h80);
      3'd3: if (op_q == 2'd0) begin cmd_a = addr_q; cmd_d = data_q; end
      3'd4: begin cmd_a = ADR_B; cmd_d = DW'(8'h55); end
      default:
        case (op_q)
          2'd1:    begin cmd_a = addr_q; cmd_d = DW'(8'h30); end
          2'd2:    begin cmd_a = addr_q; cmd_d = DW'(8'h50); end
          default: begin cmd_a = ADR_A;  cmd_d = DW'(8'h10); end
        endcase
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign mem_we    = (state == S_CMD);
  assign mem_re    = (state == S_PRD) || (state == S_CRD);
  assign mem_addr  = mem_we ? cmd_a : addr_q;
  assign mem_wdata = mem_we ? cmd_d : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q <= '0; tog_q <= 1'b0; addr_q <= '0; data_q <= '0;
      step <= '0; timer <= '0;
      prev6 <= 1'b0; have_prev <= 1'b0;
      conf_n <= 1'b0; conf_bad <= 1'b0;
      done <= 1'b0; error <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0; error <= 1'b0; timeout <= 1'b0;
      case (state)
        S_IDLE:
          if (start) begin
            op_q <= op; tog_q <= toggle_mode;
            addr_q <= target_addr; data_q <= prog_data;
            step <= '0; have_prev <= 1'b0;
            state <= S_CMD;
          end
        S_CMD:
          if (step == last_step) begin
            timer <= '0;
            state <= S_PRD;
          end else begin
            step <= step + 3'd1;
          end
        S_PRD: begin
          timer <= timer + 1'b1;
          if (tlast) begin timeout <= 1'b1; state <= S_IDLE; end
          else state <= S_PEV;
        end
        S_PEV: begin
          timer <= timer + 1'b1;
          prev6 <= mem_rdata[6];
          have_prev <= 1'b1;
          if (hit && rd_ok) begin done <= 1'b1; state <= S_IDLE; end
          else if (tlast) begin timeout <= 1'b1; state <= S_IDLE; end
          else if (hit) begin conf_n <= 1'b0; conf_bad <= 1'b0; state <= S_CRD; end
          else state <= S_PRD;
        end
        S_CRD: begin
          timer <= timer + 1'b1;
          if (tlast) begin timeout <= 1'b1; state <= S_IDLE; end
          else state <= S_CEV;
        end
        S_CEV: begin
          timer <= timer + 1'b1;
          if (conf_n) begin
            if (conf_bad || !rd_ok) error <= 1'b1;
            else done <= 1'b1;
            state <= S_IDLE;
          end else if (tlast) begin
            timeout <= 1'b1; state <= S_IDLE;
          end else begin
            conf_bad <= !rd_ok; conf_n <= 1'b1; state <= S_CRD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error, timeout}));
  assert_flag_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error || timeout) |-> !busy);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
  assert_read_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re && !mem_we);
  assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (timer <= T_LAST));
endmodule

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;
  localparam int AW = 20, DW = 16, LIM = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0, toggle_mode = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] target_addr = '0, mem_addr;
  logic [DW-1:0] prog_data = '0, mem_wdata, mem_rdata;
  logic mem_we, mem_re, busy, done, error, timeout;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .TIMEOUT_CYC(LIM)) u_flash_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .toggle_mode(toggle_mode),
    .target_addr(target_addr), .prog_data(prog_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .error(error), .timeout(timeout));

  int checks = 0, fails = 0, cyc = 0;
  logic m_clr = 1'b0, m_fault = 1'b0, m_race = 1'b0;
  int m_len = 4, m_busy = 0;
  logic [DW-1:0] m_exp = '0;
  int wcnt, rcnt, flg_cnt, busy_cnt, last_wcyc, first_rcyc;
  logic tog, race_pend;
  logic [AW-1:0] log_a [0:7];
  logic [DW-1:0] log_d [0:7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_clr) begin
      wcnt <= 0; rcnt <= 0; flg_cnt <= 0; busy_cnt <= 0;
      first_rcyc <= -1; last_wcyc <= -1; tog <= 1'b0; race_pend <= m_race;
    end else begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (done || error || timeout) flg_cnt <= flg_cnt + 1;
      if (mem_we) begin
        if (wcnt < 8) begin log_a[wcnt] <= mem_addr; log_d[wcnt] <= mem_wdata; end
        wcnt <= wcnt + 1; last_wcyc <= cyc;
        if (wcnt == m_len - 1) busy_cnt <= m_busy;
      end
      if (mem_re) begin
        rcnt <= rcnt + 1;
        if (first_rcyc < 0) first_rcyc <= cyc;
        if (busy_cnt > 0) begin
          mem_rdata <= m_exp; mem_rdata[7] <= ~m_exp[7]; mem_rdata[6] <= tog; tog <= ~tog;
        end else if (m_fault) mem_rdata <= m_exp ^ 16'h0001;
        else if (race_pend) begin mem_rdata <= m_exp ^ 16'h0003; race_pend <= 1'b0; end
        else mem_rdata <= m_exp;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, expv); end
  endtask

  task automatic run_op(input logic [1:0] o, input logic tm, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int b, input logic fault, input logic race,
                        output int res);
    @(negedge clk);
    m_len = (o == 2'd0) ? 4 : 6; m_busy = b; m_fault = fault; m_race = race;
    m_exp = (o == 2'd0) ? d : '1; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0; op = o; toggle_mode = tm; target_addr = a; prog_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    res = 0;
    for (int i = 0; i < 3000 && res == 0; i++) begin
      if (done) res = 1; else if (error) res = 2; else if (timeout) res = 3;
      if (res == 0) @(negedge clk);
    end
    if (res == 0) begin fails++; $display("FAIL R10 actual=no flag expected=flag"); end
    check(!busy, "R10 busy low with flag", busy, 0);
    repeat (3) @(negedge clk);
    check(flg_cnt == 1, "R10 flag pulse count", flg_cnt, 1);
  endtask

  task automatic check_prefix(input logic prog, input string tag);
    check(log_a[0] == 20'h5555 && log_d[0] == 16'hAA, tag, {log_a[0], log_d[0]}, 36'h5555_00AA);
    check(log_a[1] == 20'h2AAA && log_d[1] == 16'h55, tag, {log_a[1], log_d[1]}, 36'h2AAA_0055);
    check(log_d[2] == (prog ? 16'hA0 : 16'h80), tag, log_d[2], prog ? 16'hA0 : 16'h80);
  endtask

  task automatic t_program;
    int r;
    run_op(2'd0, 1'b0, 20'h01234, 16'h1234, 10, 1'b0, 1'b0, r);
    check(r == 1, "R5 program data polling done", r, 1);
    check(wcnt == 4, "R2 write count", wcnt, 4);
    check_prefix(1'b1, "R2 unlock");
    check(log_a[3] == 20'h01234 && log_d[3] == 16'h1234, "R2 word write", {log_a[3], log_d[3]}, 36'h01234_1234);
    check(first_rcyc == last_wcyc + 1, "R4 poll follows last write", first_rcyc, last_wcyc + 1);
  endtask

  task automatic t_erases;
    int r;
    run_op(2'd1, 1'b1, 20'h0A800, 16'h0, 15, 1'b0, 1'b0, r);
    check(r == 1, "R6 sector erase toggle done", r, 1);
    check(wcnt == 6, "R3 erase write count", wcnt, 6);
    check_prefix(1'b0, "R3 erase unlock");
    check(log_a[5] == 20'h0A800 && log_d[5] == 16'h30, "R3 sector code", {log_a[5], log_d[5]}, 36'h0A800_0030);
    run_op(2'd2, 1'b0, 20'h18000, 16'h0, 7, 1'b0, 1'b0, r);
    check(r == 1, "R5 block erase data polling done", r, 1);
    check(log_a[5] == 20'h18000 && log_d[5] == 16'h50, "R3 block code", {log_a[5], log_d[5]}, 36'h18000_0050);
    run_op(2'd3, 1'b1, 20'h00777, 16'h0, 9, 1'b0, 1'b0, r);
    check(r == 1, "R6 chip erase toggle done", r, 1);
    check(log_a[5] == 20'h5555 && log_d[5] == 16'h10, "R3 chip code", {log_a[5], log_d[5]}, 36'h05555_0010);
  endtask

  task automatic t_confirm;
    int r;
    run_op(2'd0, 1'b0, 20'h00040, 16'h5A80, 6, 1'b0, 1'b1, r);
    check(r == 1, "R7 raced read confirmed done", r, 1);
    check(rcnt == 6, "R7 two extra reads", rcnt, 6);
    run_op(2'd0, 1'b0, 20'h00042, 16'h5A80, 6, 1'b1, 1'b0, r);
    check(r == 2, "R7 persistent mismatch error", r, 2);
    check(rcnt == 6, "R7 error read count", rcnt, 6);
  endtask

  task automatic t_timeout;
    int r;
    run_op(2'd0, 1'b0, 20'h00100, 16'h00FF, LIM - 2, 1'b0, 1'b0, r);
    check(r == 1, "R8 completion in last cycle wins", r, 1);
    run_op(2'd0, 1'b0, 20'h00100, 16'h00FF, LIM - 1, 1'b0, 1'b0, r);
    check(r == 3, "R8 one cycle late times out", r, 3);
    run_op(2'd3, 1'b1, 20'h00100, 16'h0, 1000, 1'b0, 1'b0, r);
    check(r == 3, "R8 toggle mode timeout", r, 3);
    check(rcnt == LIM / 2, "R8 reads within limit", rcnt, LIM / 2);
  endtask

  task automatic t_ignore_start;
    int r;
    @(negedge clk);
    m_len = 4; m_busy = 20; m_fault = 1'b0; m_race = 1'b0; m_exp = 16'h0F0F; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0; op = 2'd0; toggle_mode = 1'b0; target_addr = 20'h00200; prog_data = 16'h0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    op = 2'd3; target_addr = 20'h00300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r = 0;
    for (int i = 0; i < 200 && r == 0; i++) begin
      if (done) r = 1; else if (error) r = 2; else if (timeout) r = 3;
      if (r == 0) @(negedge clk);
    end
    check(r == 1, "R9 original op completes", r, 1);
    check(wcnt == 4, "R9 no extra writes", wcnt, 4);
    repeat (3) @(negedge clk);
    check(wcnt == 4 && !busy, "R9 no relaunch", wcnt, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !timeout && !mem_we && !mem_re, "R1 reset state",
          {busy, done, error, timeout, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    t_program();
    t_erases();
    t_confirm();
    t_timeout();
    t_ignore_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule